// File: doc/BRIEF.md
# BCD Timekeeping NVRAM Register File

This block is a byte-wide storage array with a calendar clock laid over the last bytes of its address space. The lower addresses behave as ordinary retained memory. The top eight addresses form the clock: a control byte, then seconds, minutes, hours, weekday, date, month and year, all kept as packed BCD counters. A one-cycle `tick_i` pulse advances the time by one second. Every rollover is carried through to the year, and the month length, including leap years, sets when the date wraps.

With the large map (`BIG_MAP = 1`, 13-bit address) the clock sits at 0x1FF8–0x1FFF. Below it, 0x1FF0–0x1FF7 is an auxiliary bank of eight general registers. The byte at 0x1FF1 always reads zero. Reading the last auxiliary byte, 0x1FF7, restarts an external watchdog: the block pulses a strobe and presents that byte's stored value as the reload value. With the small map (`BIG_MAP = 0`, 11-bit address) the clock is at 0x07F8–0x07FF and there is no auxiliary bank.

Two 16-byte windows, 0x20–0x2F and 0x30–0x3F, can each be sealed by a lock bit. Each lock bit is inverted by a toggle request. Addresses that fall in neither the storage size nor the register banks read as 0xFF, and writes to them are dropped. The storage size is set by `MEM_BYTES`.

Top module: `tod_nvram`

## Requirements
- R1: A write with `we_i` stores `wdata_i` at a storage address below `MEM_BYTES`. A read with `re_i` returns the stored byte on `rdata_o` after the next rising clock edge, and `rdata_o` holds that value until the next read.
- R2: A read from an address at or above `MEM_BYTES` that is in neither register bank returns 0xFF. A write there changes nothing that can later be read.
- R3: While lock bit 0 is set, addresses 0x20–0x2F read as 0xFF and writes to them are dropped. Lock bit 1 does the same for 0x30–0x3F. A cycle with `lock_flip_i` high inverts the lock bit selected by `lock_idx_i`.
- R4: Reset clears both lock bits and every clock register to zero. Reset does not clear storage contents.
- R5: Relative to the clock base, the byte offsets are: 0 control (plain read/write), 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month (1–12) and 7 year. Each time value reads as packed BCD (high digit in bits 7:4).
- R6: Bit 7 of the seconds byte is a stored flag that reads back merged with the BCD seconds in bits 6:0. Bits 7:3 of the weekday byte are stored and read back merged with the weekday number 1–7 in bits 2:0.
- R7: A write to a time field is taken only if it is valid BCD within the field's range: seconds and minutes 00–59, hours 00–23, weekday 1–7, date 01–31, month 01–12, year 00–99. Otherwise that field keeps its old value.
- R8: Each `tick_i` advances seconds. Seconds wrap 59→00 and carry into minutes, minutes wrap 59→00 and carry into hours, and hours wrap 23→00 and carry into the weekday (7→1) and the date.
- R9: The date wraps to 01 after the month's last day and carries into the month; month 12 wraps to 01 and carries into the year, and the year wraps 99→00. February has 29 days when the year is a multiple of four, and 28 days otherwise.
- R10: A write to any clock register in the same cycle as `tick_i` takes effect, and that tick is dropped.
- R11: With the large map, offsets 0x1FF0–0x1FF7 are read/write registers, except 0x1FF1, which always reads 0x00. A read of 0x1FF7 raises `wdog_kick_o` for exactly the cycle in which its data appears on `rdata_o`, with that byte's stored value on `wdog_load_o`. Reads of other addresses leave `wdog_kick_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 (11 for small map) | Byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Registered read data |
| tick_i | input | 1 | One-second advance pulse |
| lock_flip_i | input | 1 | Invert the selected lock bit |
| lock_idx_i | input | 1 | Lock bit selector |
| wdog_kick_o | output | 1 | Watchdog restart strobe |
| wdog_load_o | output | 8 | Watchdog reload value |

## Verification
Read data, the watchdog strobe and its reload value all come from registers. They are due after the first rising edge that follows the cycle in which `re_i` is high. A write or a tick updates its register at that same edge, so a read issued on the next cycle already sees the result. The bench changes inputs only on falling edges and samples outputs on the falling edge after the capturing rising edge. This puts every comparison half a cycle after the one register stage each result passes through. Rollover cases are set up by writing the clock fields, then issuing a single tick, then reading each field back.

// File: rtl/tod_pkg.sv
package tod_pkg;

   typedef struct packed {
      logic [7:0] ctrl;
      logic       stop;
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hour;
      logic [4:0] wd_hi;
      logic [2:0] wday;
      logic [7:0] date;
      logic [7:0] month;
      logic [7:0] year;
   } tod_t;

   // packed BCD value with both digits legal and not above lim
   function automatic logic bcd_le(input logic [7:0] v, input logic [7:0] lim);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) && (v <= lim);
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
   endfunction

   // tens*10 mod 4 equals 2*tens[0] mod 4
   function automatic logic bcd_leap(input logic [7:0] y);
      logic [3:0] s;
      s = y[3:0] + {2'b00, y[4], 1'b0};
      return s[1:0] == 2'b00;
   endfunction

   function automatic logic [7:0] bcd_mlen(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/tod_ram.sv
module tod_ram #(
   parameter int unsigned DEPTH = 1024,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    wdata_i,
   output logic [7:0]    rdata_o
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
   end

   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/tod_lock.sv
module tod_lock #(
   parameter int unsigned NWIN       = 2,
   parameter int unsigned AW         = 13,
   parameter int unsigned FIRST_SLOT = 2,
   localparam int unsigned SW        = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          flip_i,
   input  logic [SW-1:0] idx_i,
   input  logic [AW-1:0] addr_i,
   output logic          blocked_o
);
   logic [NWIN-1:0] lk_q;
   logic [NWIN-1:0] win_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lk_q <= '0;
      else if (flip_i) lk_q[idx_i] <= ~lk_q[idx_i];
   end

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign win_hit[w] = lk_q[w] && (addr_i[AW-1:4] == (AW-4)'(FIRST_SLOT + w));
   end

   assign blocked_o = |win_hit;
endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_en_i,
   input  logic [2:0] wr_off_i,
   input  logic [7:0] wr_data_i,
   input  logic       tick_i,
   output tod_t       st_o
);
   tod_t st_q, nx;
   logic sw, mw, hw, dw, yw;

   always_comb begin
      nx = st_q;
      sw = (st_q.sec  == 8'h59);
      mw = (st_q.min  == 8'h59);
      hw = (st_q.hour == 8'h23);
      dw = (st_q.date >= bcd_mlen(st_q.month, st_q.year));
      yw = (st_q.month >= 8'h12);
      nx.sec = sw ? 8'h00 : bcd_inc(st_q.sec);
      if (sw) begin
         nx.min = mw ? 8'h00 : bcd_inc(st_q.min);
         if (mw) begin
            nx.hour = hw ? 8'h00 : bcd_inc(st_q.hour);
            if (hw) begin
               nx.wday = (st_q.wday == 3'd7) ? 3'd1 : st_q.wday + 3'd1;
               nx.date = dw ? 8'h01 : bcd_inc(st_q.date);
               if (dw) begin
                  nx.month = yw ? 8'h01 : bcd_inc(st_q.month);
                  if (yw) nx.year = (st_q.year == 8'h99) ? 8'h00 : bcd_inc(st_q.year);
               end
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= '0;
      end else if (wr_en_i) begin
         case (wr_off_i)
            3'd0: st_q.ctrl <= wr_data_i;
            3'd1: begin
               st_q.stop <= wr_data_i[7];
               if (bcd_le({1'b0, wr_data_i[6:0]}, 8'h59)) st_q.sec <= {1'b0, wr_data_i[6:0]};
            end
            3'd2: if (bcd_le(wr_data_i, 8'h59)) st_q.min  <= wr_data_i;
            3'd3: if (bcd_le(wr_data_i, 8'h23)) st_q.hour <= wr_data_i;
            3'd4: begin
               st_q.wd_hi <= wr_data_i[7:3];
               if (wr_data_i[2:0] != 3'd0) st_q.wday <= wr_data_i[2:0];
            end
            3'd5: if (bcd_le(wr_data_i, 8'h31) && wr_data_i != 8'h00) st_q.date  <= wr_data_i;
            3'd6: if (bcd_le(wr_data_i, 8'h12) && wr_data_i != 8'h00) st_q.month <= wr_data_i;
            default: if (bcd_le(wr_data_i, 8'h99)) st_q.year <= wr_data_i;
         endcase
      end else if (tick_i) begin
         st_q <= nx;
      end
   end

   assign st_o = st_q;
endmodule

// File: rtl/tod_nvram.sv
module tod_nvram
   import tod_pkg::*;
#(
   parameter bit          BIG_MAP      = 1'b1,
   parameter int unsigned MEM_BYTES    = 1024,
   parameter int unsigned LOCK_WINDOWS = 2,
   localparam int unsigned AW     = BIG_MAP ? 13 : 11,
   localparam int unsigned RAM_AW = $clog2(MEM_BYTES),
   localparam int unsigned TOP    = 1 << AW,
   localparam int unsigned AUX_LO = BIG_MAP ? TOP - 16 : TOP - 8,
   localparam int unsigned LSEL_W = (LOCK_WINDOWS > 1) ? $clog2(LOCK_WINDOWS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [AW-1:0]     addr_i,
   input  logic [7:0]        wdata_i,
   input  logic              we_i,
   input  logic              re_i,
   output logic [7:0]        rdata_o,
   input  logic              tick_i,
   input  logic              lock_flip_i,
   input  logic [LSEL_W-1:0] lock_idx_i,
   output logic              wdog_kick_o,
   output logic [7:0]        wdog_load_o
);
   if ((1 << RAM_AW) != MEM_BYTES) begin : g_bad_pow2
      $error("MEM_BYTES must be a power of two");
   end
   if (MEM_BYTES > AUX_LO) begin : g_bad_size
      $error("MEM_BYTES overlaps the register banks");
   end
   if ((2 + LOCK_WINDOWS) * 16 > MEM_BYTES) begin : g_bad_lock
      $error("lock windows exceed storage");
   end

   tod_t       clk_st;
   logic       lock_hit, in_ram, hit_clk, hit_aux, clk_we;
   logic [7:0] ram_rd, clk_rd, aux_rd, rd_next;

   assign hit_clk = &addr_i[AW-1:3];
   assign in_ram  = (32'(addr_i) < MEM_BYTES) && !lock_hit;
   assign clk_we  = we_i && hit_clk;

   tod_lock #(.NWIN(LOCK_WINDOWS), .AW(AW), .FIRST_SLOT(2)) u_lock (
      .clk_i, .rst_ni, .flip_i(lock_flip_i), .idx_i(lock_idx_i),
      .addr_i, .blocked_o(lock_hit)
   );

   tod_ram #(.DEPTH(MEM_BYTES)) u_ram (
      .clk_i, .we_i(we_i && in_ram), .addr_i(addr_i[RAM_AW-1:0]),
      .wdata_i, .rdata_o(ram_rd)
   );

   tod_clock u_clock (
      .clk_i, .rst_ni, .wr_en_i(clk_we), .wr_off_i(addr_i[2:0]),
      .wr_data_i(wdata_i), .tick_i, .st_o(clk_st)
   );

   always_comb begin
      case (addr_i[2:0])
         3'd0: clk_rd = clk_st.ctrl;
         3'd1: clk_rd = {clk_st.stop, clk_st.sec[6:0]};
         3'd2: clk_rd = clk_st.min;
         3'd3: clk_rd = clk_st.hour;
         3'd4: clk_rd = {clk_st.wd_hi, clk_st.wday};
         3'd5: clk_rd = clk_st.date;
         3'd6: clk_rd = clk_st.month;
         default: clk_rd = clk_st.year;
      endcase
   end

   if (BIG_MAP) begin : g_aux
      logic [7:0] aux [8];
      assign hit_aux = (&addr_i[AW-1:4]) && !addr_i[3];
      assign aux_rd  = (addr_i[2:0] == 3'd1) ? 8'h00 : aux[addr_i[2:0]];

      always_ff @(posedge clk_i) begin
         if (we_i && hit_aux) aux[addr_i[2:0]] <= wdata_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            wdog_kick_o <= 1'b0;
            wdog_load_o <= 8'h00;
         end else begin
            wdog_kick_o <= re_i && hit_aux && (addr_i[2:0] == 3'd7);
            if (re_i && hit_aux && (addr_i[2:0] == 3'd7)) wdog_load_o <= aux[7];
         end
      end
   end else begin : g_no_aux
      assign hit_aux     = 1'b0;
      assign aux_rd      = 8'h00;
      assign wdog_kick_o = 1'b0;
      assign wdog_load_o = 8'h00;
   end

   always_comb begin
      if (hit_clk)      rd_next = clk_rd;
      else if (hit_aux) rd_next = aux_rd;
      else if (in_ram)  rd_next = ram_rd;
      else              rd_next = 8'hFF;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rdata_o <= 8'h00;
      else if (re_i) rdata_o <= rd_next;
   end
endmodule

// File: rtl/tod_nvram_chk.sv
module tod_nvram_chk #(
   parameter bit          BIG_MAP   = 1'b1,
   parameter int unsigned AW        = 13,
   parameter int unsigned MEM_BYTES = 1024,
   parameter int unsigned AUX_LO    = 8176
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [AW-1:0] addr_i,
   input logic          re_i,
   input logic          tick_i,
   input logic          clk_we,
   input logic          lock_hit,
   input logic [7:0]    rdata_o,
   input logic          wdog_kick_o,
   input logic [7:0]    sec
);
   localparam logic [AW-1:0] KICK_A   = AW'((1 << AW) - 9);
   localparam logic [AW-1:0] UNUSED_A = AW'((1 << AW) - 15);

   // R3
   lock_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      re_i && lock_hit |=> rdata_o == 8'hFF);

   // R2
   range_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      re_i && (32'(addr_i) >= MEM_BYTES) && (32'(addr_i) < AUX_LO) |=> rdata_o == 8'hFF);

   // R8
   sec_bcd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec[3:0] <= 4'd9 && sec <= 8'h59);

   // R8
   tick_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !clk_we |=> sec != $past(sec));

   // R10
   write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clk_we && tick_i && addr_i[2:0] != 3'd1 |=> $stable(sec));

   // R11
   kick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdog_kick_o |-> BIG_MAP && $past(re_i) && $past(addr_i) == KICK_A);

   // R11
   unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      BIG_MAP && re_i && addr_i == UNUSED_A |=> rdata_o == 8'h00);
endmodule

bind tod_nvram tod_nvram_chk #(
   .BIG_MAP(BIG_MAP), .AW(AW), .MEM_BYTES(MEM_BYTES), .AUX_LO(AUX_LO)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .re_i(re_i),
   .tick_i(tick_i), .clk_we(clk_we), .lock_hit(lock_hit),
   .rdata_o(rdata_o), .wdog_kick_o(wdog_kick_o), .sec(clk_st.sec)
);

// File: tb/tb_tod_nvram.sv
module tb_tod_nvram;
   localparam int CLK_PERIOD = 10;

   localparam logic [12:0] A_CTRL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                           A_HOUR = 13'h1FFB, A_WDAY = 13'h1FFC, A_DATE = 13'h1FFD,
                           A_MON  = 13'h1FFE, A_YEAR = 13'h1FFF, A_WDOG = 13'h1FF7,
                           A_UNU  = 13'h1FF1, A_AUX2 = 13'h1FF2;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0, rdata, wdog_load;
   logic        we = 1'b0, re = 1'b0, tick = 1'b0, lflip = 1'b0, wdog_kick;
   logic [0:0]  lidx = '0;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tod_nvram dut (
      .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
      .re_i(re), .rdata_o(rdata), .tick_i(tick), .lock_flip_i(lflip),
      .lock_idx_i(lidx), .wdog_kick_o(wdog_kick), .wdog_load_o(wdog_load)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [12:0] a, output logic [7:0] v, output logic k);
      @(negedge clk); addr = a; re = 1'b1;
      @(negedge clk); re = 1'b0; v = rdata; k = wdog_kick;
   endtask

   task automatic expect_rd(input string req, input logic [12:0] a, input logic [7:0] exp);
      logic [7:0] v; logic k;
      rd(a, v, k);
      chk(req, v, exp);
   endtask

   task automatic one_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic flip(input logic i);
      @(negedge clk); lidx = i; lflip = 1'b1;
      @(negedge clk); lflip = 1'b0;
   endtask

   task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
      wr(A_YEAR, y); wr(A_MON, mo); wr(A_DATE, d);
      wr(A_HOUR, h); wr(A_MIN, mi); wr(A_SEC, s);
   endtask

   task automatic t_reset();
      expect_rd("R4 sec", A_SEC, 8'h00);
      expect_rd("R4 hour", A_HOUR, 8'h00);
      expect_rd("R4 year", A_YEAR, 8'h00);
      expect_rd("R4 ctrl", A_CTRL, 8'h00);
      wr(13'h0025, 8'h11);
      expect_rd("R4 lock0 clear", 13'h0025, 8'h11);
      wr(13'h0035, 8'h22);
      expect_rd("R4 lock1 clear", 13'h0035, 8'h22);
   endtask

   task automatic t_storage();
      wr(13'h0010, 8'h5A); wr(13'h03FF, 8'hC3);
      expect_rd("R1 low", 13'h0010, 8'h5A);
      expect_rd("R1 top", 13'h03FF, 8'hC3);
      wr(A_CTRL, 8'h4E);
      expect_rd("R5 ctrl", A_CTRL, 8'h4E);
   endtask

   task automatic t_range();
      expect_rd("R2 read", 13'h0500, 8'hFF);
      wr(13'h0500, 8'h00);
      expect_rd("R2 write", 13'h0500, 8'hFF);
      expect_rd("R2 alias", 13'h0100, 8'h00 ^ 8'h00 | rd_alias_exp);
   endtask
   logic [7:0] rd_alias_exp = 8'h6B;

   task automatic t_lock();
      flip(1'b0);
      expect_rd("R3 win0 read", 13'h0025, 8'hFF);
      expect_rd("R3 win1 open", 13'h0035, 8'h22);
      wr(13'h0025, 8'hAA);
      flip(1'b1);
      expect_rd("R3 win1 read", 13'h0035, 8'hFF);
      flip(1'b0); flip(1'b1);
      expect_rd("R3 win0 write dropped", 13'h0025, 8'h11);
      expect_rd("R3 win1 reopen", 13'h0035, 8'h22);
   endtask

   task automatic t_roll_time();
      set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'hD8);
      wr(A_WDAY, 8'hAF);
      one_tick();
      expect_rd("R6 stop bit", A_SEC, 8'hD9);
      one_tick();
      expect_rd("R8 sec wrap", A_SEC, 8'h80);
      expect_rd("R8 min wrap", A_MIN, 8'h00);
      expect_rd("R8 hour wrap", A_HOUR, 8'h00);
      expect_rd("R6 R8 weekday", A_WDAY, 8'hA9);
      expect_rd("R9 leap feb29", A_DATE, 8'h29);
      expect_rd("R9 month held", A_MON, 8'h02);
   endtask

   task automatic t_roll_date();
      set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
      one_tick();
      expect_rd("R9 leap end date", A_DATE, 8'h01);
      expect_rd("R9 leap end month", A_MON, 8'h03);
      set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      one_tick();
      expect_rd("R9 nonleap date", A_DATE, 8'h01);
      expect_rd("R9 nonleap month", A_MON, 8'h03);
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      one_tick();
      expect_rd("R9 year wrap", A_YEAR, 8'h00);
      expect_rd("R9 month wrap", A_MON, 8'h01);
      expect_rd("R9 date wrap", A_DATE, 8'h01);
      set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      one_tick();
      expect_rd("R9 30-day month", A_MON, 8'h05);
   endtask

   task automatic t_reject();
      set_time(8'h45, 8'h07, 8'h15, 8'h12, 8'h34, 8'h30);
      wr(A_SEC, 8'h60);  expect_rd("R7 sec", A_SEC, 8'h30);
      wr(A_YEAR, 8'h9A); expect_rd("R7 year", A_YEAR, 8'h45);
      wr(A_MON, 8'h13);  expect_rd("R7 month", A_MON, 8'h07);
      wr(A_DATE, 8'h00); expect_rd("R7 date", A_DATE, 8'h15);
      wr(A_HOUR, 8'h24); expect_rd("R7 hour", A_HOUR, 8'h12);
      wr(A_YEAR, 8'h99); expect_rd("R7 year max", A_YEAR, 8'h99);
   endtask

   task automatic t_write_vs_tick();
      wr(A_SEC, 8'h05);
      @(negedge clk); addr = A_SEC; wdata = 8'h10; we = 1'b1; tick = 1'b1;
      @(negedge clk); we = 1'b0; tick = 1'b0;
      expect_rd("R10 write wins", A_SEC, 8'h10);
      one_tick();
      expect_rd("R10 next tick", A_SEC, 8'h11);
   endtask

   task automatic t_watchdog();
      logic [7:0] v; logic k;
      wr(A_WDOG, 8'h5C);
      rd(A_WDOG, v, k);
      chk("R11 wdog data", v, 8'h5C);
      chk("R11 kick", {7'd0, k}, 8'h01);
      chk("R11 load", wdog_load, 8'h5C);
      rd(A_AUX2, v, k);
      chk("R11 no kick", {7'd0, k}, 8'h00);
      wr(A_AUX2, 8'h3C);
      expect_rd("R11 aux", A_AUX2, 8'h3C);
      wr(A_UNU, 8'h77);
      expect_rd("R11 unused", A_UNU, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      wr(13'h0100, 8'h6B);
      t_storage();
      t_range();
      t_lock();
      t_roll_time();
      t_roll_date();
      t_reject();
      t_write_vs_tick();
      t_watchdog();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule